// File: doc/BRIEF.md
# Top-Window Memory Select Decoder

This block sits between the address bus of an 8-bit processor and a bank of byte-wide nonvolatile memory devices. The devices together fill the highest part of the byte address space. On each clock the block takes the full address and the read and write requests. From them it registers one active-low select per device, the in-device byte address, and active-low output-enable and write-enable strobes.

A device whose select is high is in standby, or power-down. A select goes low only while an access addressed inside the window is in progress. A request that asks for a read and a write in the same cycle does nothing to any device and raises an error flag instead. Every output is registered, so it reflects the inputs of the previous clock edge.

With the default parameters the bus is 20 bits wide (1 MB). There are four 32K x 8 devices, and the window spans 0xE0000 to 0xFFFFF.

Top module: `memsel_decoder`

## Requirements
- R1: While reset is held, and in the first cycle after it, every select, `rd_en_n` and `wr_en_n` are 1, `req_err` is 0 and `dev_addr` is 0.
- R2: A select can be low only if address bits [19:17] were 3'b111. Any address below 0xE0000 leaves all four selects high.
- R3: For an in-window read or write, the select at index `bus_addr[16:15]` goes low: `dev_sel_n` bit k for device k, with 0xE0000, 0xE8000, 0xF0000 and 0xF8000 as the bases of devices 0 to 3.
- R4: `dev_addr` equals `bus_addr[14:0]` from the previous cycle, unchanged.
- R5: An in-window read (`rd_req`=1, `wr_req`=0) drives `rd_en_n` low and keeps `wr_en_n` high.
- R6: An in-window write (`wr_req`=1, `rd_req`=0) drives `wr_en_n` low and keeps `rd_en_n` high.
- R7: At most one select is low at any time. Whenever all selects are high, both strobes are high.
- R8: When `rd_req` and `wr_req` are both 1, at any address, the next cycle shows `req_err`=1, all selects high and both strobes high. Otherwise `req_err` is 0.
- R9: With no request, all devices stay deselected and both strobes stay high, even for an in-window address.
- R10: All outputs follow their inputs with a latency of exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 20 | Processor byte address |
| rd_req | input | 1 | Processor read request |
| wr_req | input | 1 | Processor write request |
| dev_sel_n | output | 4 | Active-low device selects; high means standby |
| dev_addr | output | 15 | Byte address inside the selected device |
| rd_en_n | output | 1 | Active-low output enable |
| wr_en_n | output | 1 | Active-low write enable |
| req_err | output | 1 | Read and write requested together |

## Verification
The bench builds the block with its default parameters: a 20-bit bus, 15-bit device addresses and four devices. This makes the window edges (0xDFFFF against 0xE0000, and each 32 KB seam up to 0xFFFFF) reachable with short directed vectors. Random addresses are biased so that half of them fall inside the window. All four request combinations are driven at both in-window and out-of-window addresses, so the clash rule and the idle rule are each tested on both sides of the boundary.

// File: rtl/memsel_pkg.sv
package memsel_pkg;

    typedef enum logic [1:0] {
        REQ_IDLE  = 2'd0,
        REQ_READ  = 2'd1,
        REQ_WRITE = 2'd2,
        REQ_CLASH = 2'd3
    } req_kind_e;

    function automatic req_kind_e classify_req(input logic rd, input logic wr);
        req_kind_e k;
        case ({wr, rd})
            2'b01:   k = REQ_READ;
            2'b10:   k = REQ_WRITE;
            2'b11:   k = REQ_CLASH;
            default: k = REQ_IDLE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/memsel_window.sv
module memsel_window #(
    parameter int TAG_W = 3
) (
    input  logic [TAG_W-1:0] tag,
    output logic             hit
);
    // The window is the top slice of the space: every upper tag bit set.
    always_comb begin
        hit = (tag == {TAG_W{1'b1}});
    end
endmodule

// File: rtl/memsel_sel_decode.sv
module memsel_sel_decode #(
    parameter int NUM_DEV = 4,
    parameter int SEL_W   = 2
) (
    input  logic               en,
    input  logic [SEL_W-1:0]   idx,
    output logic [NUM_DEV-1:0] sel_n
);
    for (genvar g = 0; g < NUM_DEV; g++) begin : g_sel
        always_comb begin
            sel_n[g] = !(en && (idx == SEL_W'(g)));
        end
    end
endmodule

// File: rtl/memsel_decoder.sv
module memsel_decoder
    import memsel_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int DEV_AW  = 15,
    parameter int NUM_DEV = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               rd_req,
    input  logic               wr_req,
    output logic [NUM_DEV-1:0] dev_sel_n,
    output logic [DEV_AW-1:0]  dev_addr,
    output logic               rd_en_n,
    output logic               wr_en_n,
    output logic               req_err
);
    localparam int SEL_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
    localparam int TAG_W = ADDR_W - DEV_AW - SEL_W;

    typedef struct packed {
        logic [NUM_DEV-1:0] sel_n;
        logic [DEV_AW-1:0]  addr;
        logic               oe_n;
        logic               we_n;
        logic               err;
    } out_t;

    out_t      st_d, st_q;
    req_kind_e kind;
    logic      win_hit;
    logic      access;
    logic [NUM_DEV-1:0] sel_n_dec;

    memsel_window #(.TAG_W(TAG_W)) u_window (
        .tag (bus_addr[ADDR_W-1 -: TAG_W]),
        .hit (win_hit)
    );

    memsel_sel_decode #(.NUM_DEV(NUM_DEV), .SEL_W(SEL_W)) u_dec (
        .en    (access),
        .idx   (bus_addr[DEV_AW +: SEL_W]),
        .sel_n (sel_n_dec)
    );

    always_comb begin
        kind   = classify_req(rd_req, wr_req);
        access = win_hit && (kind == REQ_READ || kind == REQ_WRITE);
        st_d       = st_q;
        st_d.sel_n = sel_n_dec;
        st_d.addr  = bus_addr[DEV_AW-1:0];
        st_d.oe_n  = !(access && kind == REQ_READ);
        st_d.we_n  = !(access && kind == REQ_WRITE);
        st_d.err   = (kind == REQ_CLASH);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sel_n <= '1;
            st_q.addr  <= '0;
            st_q.oe_n  <= 1'b1;
            st_q.we_n  <= 1'b1;
            st_q.err   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dev_sel_n = st_q.sel_n;
    assign dev_addr  = st_q.addr;
    assign rd_en_n   = st_q.oe_n;
    assign wr_en_n   = st_q.we_n;
    assign req_err   = st_q.err;

    // R7
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~dev_sel_n));
    // R7
    strobe_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&dev_sel_n) |-> (rd_en_n && wr_en_n));
    // R5 R6
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_en_n && !wr_en_n));
    // R8
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> ((&dev_sel_n) && rd_en_n && wr_en_n));
    // R2
    outside_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[ADDR_W-1 -: TAG_W] != {TAG_W{1'b1}}) |=> (&dev_sel_n));
    // R8
    clash_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && wr_req) |=> req_err);
    // R4
    addr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (dev_addr == $past(bus_addr[DEV_AW-1:0])));
endmodule

// File: tb/sim_memsel_decoder.sv
module sim_memsel_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] bus_addr = '0;
    logic        rd_req = 1'b0;
    logic        wr_req = 1'b0;
    logic [3:0]  dev_sel_n;
    logic [14:0] dev_addr;
    logic        rd_en_n, wr_en_n, req_err;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    // expected outputs for the next sample
    logic [3:0]  e_sel = 4'hF;
    logic [14:0] e_addr = '0;
    logic        e_oe = 1'b1, e_we = 1'b1, e_err = 1'b0;
    string       e_tag = "R1";

    always #4 clk = ~clk;   // 125 MHz

    memsel_decoder u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
        .rd_req(rd_req), .wr_req(wr_req),
        .dev_sel_n(dev_sel_n), .dev_addr(dev_addr),
        .rd_en_n(rd_en_n), .wr_en_n(wr_en_n), .req_err(req_err)
    );

    task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Samples what the previous vector produced (R10: one clock later).
    task automatic check_now();
        cmp({e_tag, " sel"}, 32'(dev_sel_n), 32'(e_sel));
        cmp("R4 addr", 32'(dev_addr), 32'(e_addr));
        cmp("R5 rd_en_n", 32'(rd_en_n), 32'(e_oe));
        cmp("R6 wr_en_n", 32'(wr_en_n), 32'(e_we));
        cmp("R8 err", 32'(req_err), 32'(e_err));
        // R7: a single select low, strobes idle when nothing selected
        cmp("R7 onehot", 32'($countones(~dev_sel_n) <= 1), 32'd1);
    endtask

    task automatic apply(input logic [19:0] a, input logic rd, input logic wr);
        @(negedge clk);
        check_now();
        bus_addr = a; rd_req = rd; wr_req = wr;
        begin
            bit in_win;
            in_win = (a >= 20'hE0000);
            e_sel = 4'hF;
            e_addr = a[14:0];
            e_err = rd && wr;
            e_oe = 1'b1; e_we = 1'b1;
            if (rd && wr)            e_tag = "R8";
            else if (!in_win)        e_tag = "R2";
            else if (!rd && !wr)     e_tag = "R9";
            else                     e_tag = "R3";
            if (in_win && (rd != wr)) begin
                e_sel[(a - 20'hE0000) / 20'h8000] = 1'b0;
                e_oe = !rd;
                e_we = !wr;
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        check_now();
        @(negedge clk);
        rst_n = 1'b1;
        // R1: first vector's check sees the reset values
        apply(20'hE0000, 1'b1, 1'b0);
        apply(20'hE7FFF, 1'b1, 1'b0);
        apply(20'hE8000, 1'b0, 1'b1);
        apply(20'hEFFFF, 1'b1, 1'b0);
        apply(20'hF0000, 1'b0, 1'b1);
        apply(20'hF7FFF, 1'b1, 1'b0);
        apply(20'hF8000, 1'b1, 1'b0);
        apply(20'hFFFFF, 1'b0, 1'b1);
        apply(20'hDFFFF, 1'b1, 1'b0);   // R2 just below window
        apply(20'h00000, 1'b0, 1'b1);
        apply(20'h7FFFF, 1'b1, 1'b0);
        apply(20'hF1234, 1'b0, 1'b0);   // R9 idle in window
        apply(20'hE4321, 1'b1, 1'b1);   // R8 clash in window
        apply(20'h12345, 1'b1, 1'b1);   // R8 clash outside
        apply(20'hFABCD, 1'b0, 1'b1);
        for (int i = 0; i < 600; i++) begin
            logic [19:0] a;
            a = 20'($urandom);
            if ($urandom_range(1, 0) == 1) a[19:17] = 3'b111;
            apply(a, 1'($urandom), 1'($urandom));
        end
        apply(20'h0, 1'b0, 1'b0);
        @(negedge clk);
        check_now();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule